// File: doc/BRIEF.md
# Block-Transfer Mailbox Register Interface

This block is the management-controller side of a block-transfer message mailbox. A 32-bit word-register port gives access to seven registers: configuration, interrupt enable, interrupt status, a spare register, a control/handshake register, a byte-wide data port and an interrupt mask. An inbound message arrives as a framed byte stream on a valid/ready side port. The block decodes the framing and stores the payload. Firmware then reads the payload through the data port, and the first byte read is the payload length. Firmware builds an outbound message by writing bytes to the data port. A control-register command sends that message out on a second byte stream.

The control register carries the handshake flags: host-to-controller attention, controller-to-host attention, controller busy and host busy. Each write to it performs exactly one command, chosen by a fixed bit priority. A new inbound frame cannot be accepted while a received message still waits for firmware, or while firmware holds the busy flag. A single level interrupt reflects the enabled status bits.

Top module: `btMailbox`

## Requirements
- R1: After reset every mapped register reads zero, `irq` is low, `rxReady` is high, `txValid` is low, and the first data-port read returns a length of 0.
- R2: Word registers sit at byte offsets 0x00 config, 0x04 interrupt enable, 0x08 interrupt status, 0x0C spare, 0x10 control, 0x14 data and 0x18 interrupt mask. Config, spare and mask store all 32 written bits. Offset 0x1C reads zero.
- R3: Control bits are 0x01 clear-write, 0x02 clear-read, 0x04 host attention (H2B), 0x08 start-send (B2H), 0x40 host busy and 0x80 controller busy. A control write acts only on its highest-priority set bit, in the order 0x01, 0x02, 0x04, 0x80, 0x08. Clear-write empties the outbound buffer.
- R4: A clear-read command makes the next data-port read return the inbound length.
- R5: Writing 0x04 clears the H2B flag, and writing 0x80 toggles the busy flag (bit 7). A write with none of bits 0x01, 0x02, 0x04, 0x08 or 0x80 changes no flag.
- R6: The start-send command sets control bits 0x08 and 0x40. It then presents the outbound bytes in write order on `txByte` with a `txValid`/`txReady` handshake, and clears both bits after the last byte.
- R7: A data-port write appends bits [7:0] to the outbound buffer only while it holds fewer than DEPTH (64) bytes.
- R8: Data-port reads return the length first, then the bytes in order, then 0 for every read past the end.
- R9: When H2B is newly high with enable bit 0 set, status bit 0 is set and a message-waiting state is entered. When host busy is newly high with enable bit 6 set, status bit 6 is set. Writing 1 to a status bit clears it. `irq` is high exactly while some status bit among 0x41 is set with its enable bit.
- R10: `rxReady` is low while a message waits or the busy flag is set. A byte offered then is not taken.
- R11: Inbound framing: 0xA0 ends a message and sets H2B, but only if the length is nonzero, no escape is pending and no overflow occurred. 0xA1 discards the collected bytes. 0xAA escapes the next byte, whose bit 4 is then cleared. Past DEPTH bytes an overflow state ignores all further bytes and end marks.
- R12: Any control write that leaves the busy flag clear also clears the waiting state, the pending escape, the inbound length and the overflow state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (advances the data port) |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for the addressed register, valid in the strobe cycle |
| irq | output | 1 | Level interrupt |
| rxValid | input | 1 | Inbound byte valid |
| rxByte | input | 8 | Inbound framed byte |
| rxReady | output | 1 | Inbound byte accepted when high |
| txValid | output | 1 | Outbound byte valid |
| txByte | output | 8 | Outbound byte |
| txReady | input | 1 | Outbound consumer ready |

## Verification
The hardest state to reach from the ports is an inbound message that is held intact while firmware inspects it. Any control write with the busy flag clear wipes the receive state. Because of this, every read-back scenario first toggles the busy flag high with a lone 0x80 write, then issues the attention clear and clear-read commands, and only then reads. It finishes with a second 0x80 write, which both releases the flag and proves that the receive state was reset. The overflow and pending-escape cases are reached by streaming more than DEPTH bytes, or an escape right before an end mark. The outcome is then judged through the control flags and the length byte.

// File: rtl/btmbPkg.sv
package btmbPkg;
  // Word index of each register (byte offset / 4)
  localparam int W_CFG   = 0;
  localparam int W_IEN   = 1;
  localparam int W_STS   = 2;
  localparam int W_SPARE = 3;
  localparam int W_CTRL  = 4;
  localparam int W_DATA  = 5;
  localparam int W_MASK  = 6;

  // Control bit positions
  localparam int C_CLR_WR = 0;
  localparam int C_CLR_RD = 1;
  localparam int C_H2B    = 2;
  localparam int C_B2H    = 3;
  localparam int C_HBUSY  = 6;
  localparam int C_BBUSY  = 7;

  // Status/enable bits that can drive the interrupt
  localparam logic [31:0] IRQ_SRC = 32'h0000_0041;

  // Inbound stream framing codes
  localparam logic [7:0] MARK_MSG = 8'hA0;
  localparam logic [7:0] MARK_CMD = 8'hA1;
  localparam logic [7:0] MARK_ESC = 8'hAA;
  localparam logic [7:0] ESC_FLIP = 8'h10;

  typedef struct packed {
    logic clrWr;
    logic clrRd;
    logic rxReset;
    logic txStart;
    logic pushOut;
    logic popIn;
  } mbStrobe_t;
endpackage

// File: rtl/btmbCtrl.sv
module btmbCtrl import btmbPkg::*; #(
  parameter int WA_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic            rdEn,
  input  logic [WA_W-1:0] wordAddr,
  input  logic [31:0]     wrData,
  input  logic            msgEnd,
  input  logic            txDone,
  output mbStrobe_t       stb,
  output logic [7:0]      ctrlByte,
  output logic [31:0]     cfgReg,
  output logic [31:0]     ienReg,
  output logic [31:0]     stsReg,
  output logic [31:0]     spareReg,
  output logic [31:0]     maskReg,
  output logic            irq,
  output logic            rxReady
);
  logic bBusy, hBusy, b2h, h2b, waiting;
  logic h2bTermQ, hbTermQ;
  logic ctrlWr, stsWr, h2bClr, bToggle, bBusyNext;
  logic h2bRise, hbRise;
  logic [31:0] stsNext;

  assign ctrlWr = wrEn && (wordAddr == WA_W'(W_CTRL));
  assign stsWr  = wrEn && (wordAddr == WA_W'(W_STS));

  // One command per control write, fixed priority
  always_comb begin
    stb         = '0;
    h2bClr      = 1'b0;
    bToggle     = 1'b0;
    stb.pushOut = wrEn && (wordAddr == WA_W'(W_DATA));
    stb.popIn   = rdEn && (wordAddr == WA_W'(W_DATA));
    if (ctrlWr) begin
      if (wrData[C_CLR_WR])      stb.clrWr   = 1'b1;
      else if (wrData[C_CLR_RD]) stb.clrRd   = 1'b1;
      else if (wrData[C_H2B])    h2bClr      = 1'b1;
      else if (wrData[C_BBUSY])  bToggle     = 1'b1;
      else if (wrData[C_B2H])    stb.txStart = 1'b1;
    end
    bBusyNext   = bBusy ^ bToggle;
    stb.rxReset = ctrlWr && !bBusyNext;
  end

  assign h2bRise = (h2b && ienReg[0]) && !h2bTermQ;
  assign hbRise  = (hBusy && ienReg[6]) && !hbTermQ;

  always_comb begin
    stsNext = stsReg;
    if (stsWr) stsNext = stsNext & ~wrData;
    if (h2bRise) stsNext[0] = 1'b1;
    if (hbRise)  stsNext[6] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= '0; ienReg <= '0; stsReg <= '0; spareReg <= '0; maskReg <= '0;
      bBusy <= 1'b0; hBusy <= 1'b0; b2h <= 1'b0; h2b <= 1'b0; waiting <= 1'b0;
      h2bTermQ <= 1'b0; hbTermQ <= 1'b0;
    end else begin
      if (wrEn && wordAddr == WA_W'(W_CFG))   cfgReg   <= wrData;
      if (wrEn && wordAddr == WA_W'(W_IEN))   ienReg   <= wrData;
      if (wrEn && wordAddr == WA_W'(W_SPARE)) spareReg <= wrData;
      if (wrEn && wordAddr == WA_W'(W_MASK))  maskReg  <= wrData;
      stsReg <= stsNext;
      bBusy  <= bBusyNext;
      if (h2bClr)      h2b <= 1'b0;
      else if (msgEnd) h2b <= 1'b1;
      if (stb.txStart) begin
        b2h <= 1'b1; hBusy <= 1'b1;
      end else if (txDone) begin
        b2h <= 1'b0; hBusy <= 1'b0;
      end
      h2bTermQ <= h2b && ienReg[0];
      hbTermQ  <= hBusy && ienReg[6];
      if (stb.rxReset)  waiting <= 1'b0;
      else if (h2bRise) waiting <= 1'b1;
    end
  end

  assign ctrlByte = {bBusy, hBusy, 2'b00, b2h, h2b, 2'b00};
  assign irq      = |(stsReg & ienReg & IRQ_SRC);
  assign rxReady  = !waiting && !bBusy;
endmodule

// File: rtl/btmbData.sv
module btmbData import btmbPkg::*; #(
  parameter int DEPTH = 64,
  localparam int LEN_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  mbStrobe_t        stb,
  input  logic [7:0]       wrByte,
  input  logic             rxValid,
  input  logic [7:0]       rxByte,
  input  logic             rxReady,
  input  logic             txReady,
  output logic             msgEnd,
  output logic             txDone,
  output logic             txValid,
  output logic [7:0]       txByte,
  output logic [7:0]       rdByte,
  output logic [LEN_W-1:0] inLen,
  output logic [LEN_W-1:0] outLen,
  output logic             lenNext
);
  localparam logic [LEN_W-1:0] FULL = LEN_W'(DEPTH);

  logic [7:0] inBuf  [DEPTH];
  logic [7:0] outBuf [DEPTH];
  logic [LEN_W-1:0] rdIdx, txIdx;
  logic esc, over, txActive;
  logic rxTake, isMark, cmdEnd, endOk;
  logic [7:0] plainByte;

  // ---------------- inbound framing ----------------
  assign rxTake    = rxValid && rxReady && !stb.rxReset;
  assign isMark    = (rxByte == MARK_MSG) || (rxByte == MARK_CMD);
  assign endOk     = !esc && !over && (inLen != '0);
  assign msgEnd    = rxTake && (rxByte == MARK_MSG) && endOk;
  assign cmdEnd    = rxTake && (rxByte == MARK_CMD) && endOk;
  assign plainByte = esc ? (rxByte & ~ESC_FLIP) : rxByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      esc <= 1'b0; over <= 1'b0; inLen <= '0;
      for (int i = 0; i < DEPTH; i++) inBuf[i] <= '0;
    end else if (stb.rxReset) begin
      esc <= 1'b0; over <= 1'b0; inLen <= '0;
    end else if (rxTake) begin
      if (isMark) begin
        if (cmdEnd) inLen <= '0;
      end else if (rxByte == MARK_ESC) begin
        if (!over) esc <= 1'b1;
      end else begin
        esc <= 1'b0;
        if (!over) begin
          if (inLen == FULL) over <= 1'b1;
          else begin
            inBuf[inLen[IDX_W-1:0]] <= plainByte;
            inLen <= inLen + 1'b1;
          end
        end
      end
    end
  end

  // ---------------- data-port read side ----------------
  always_comb begin
    if (lenNext)           rdByte = 8'(inLen);
    else if (rdIdx < inLen) rdByte = inBuf[rdIdx[IDX_W-1:0]];
    else                   rdByte = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenNext <= 1'b1; rdIdx <= '0;
    end else if (stb.clrRd) begin
      lenNext <= 1'b1;
    end else if (stb.popIn) begin
      if (lenNext) begin
        lenNext <= 1'b0; rdIdx <= '0;
      end else if (rdIdx < inLen) begin
        rdIdx <= rdIdx + 1'b1;
      end
    end
  end

  // ---------------- outbound buffer and sender ----------------
  assign txValid = txActive && (txIdx != outLen);
  assign txDone  = txActive && (txIdx == outLen);
  assign txByte  = outBuf[txIdx[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outLen <= '0; txActive <= 1'b0; txIdx <= '0;
      for (int i = 0; i < DEPTH; i++) outBuf[i] <= '0;
    end else begin
      if (stb.clrWr) begin
        outLen <= '0;
        for (int i = 0; i < DEPTH; i++) outBuf[i] <= '0;
      end else if (stb.pushOut && outLen != FULL) begin
        outBuf[outLen[IDX_W-1:0]] <= wrByte;
        outLen <= outLen + 1'b1;
      end
      if (stb.txStart) begin
        txActive <= 1'b1; txIdx <= '0;
      end else if (txDone) begin
        txActive <= 1'b0;
      end else if (txValid && txReady) begin
        txIdx <= txIdx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/btMailbox.sv
module btMailbox import btmbPkg::*; #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 5,
  localparam int WA_W  = ADDR_W - 2,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              irq,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  output logic              rxReady,
  output logic              txValid,
  output logic [7:0]        txByte,
  input  logic              txReady
);
  logic [WA_W-1:0] wordAddr;
  logic unusedAddrLow;
  mbStrobe_t stb;
  logic msgEnd, txDone, lenNext;
  logic [7:0] ctrlByte, rdByte;
  logic [31:0] cfgReg, ienReg, stsReg, spareReg, maskReg;
  logic [LEN_W-1:0] inLen, outLen;

  assign wordAddr      = busAddr[ADDR_W-1:2];
  assign unusedAddrLow = ^busAddr[1:0];

  btmbCtrl #(.WA_W(WA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(busWrEn), .rdEn(busRdEn),
    .wordAddr(wordAddr), .wrData(busWrData), .msgEnd(msgEnd), .txDone(txDone),
    .stb(stb), .ctrlByte(ctrlByte), .cfgReg(cfgReg), .ienReg(ienReg),
    .stsReg(stsReg), .spareReg(spareReg), .maskReg(maskReg),
    .irq(irq), .rxReady(rxReady)
  );

  btmbData #(.DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wrByte(busWrData[7:0]),
    .rxValid(rxValid), .rxByte(rxByte), .rxReady(rxReady), .txReady(txReady),
    .msgEnd(msgEnd), .txDone(txDone), .txValid(txValid), .txByte(txByte),
    .rdByte(rdByte), .inLen(inLen), .outLen(outLen), .lenNext(lenNext)
  );

  always_comb begin
    case (wordAddr)
      WA_W'(W_CFG):   busRdData = cfgReg;
      WA_W'(W_IEN):   busRdData = ienReg;
      WA_W'(W_STS):   busRdData = stsReg;
      WA_W'(W_SPARE): busRdData = spareReg;
      WA_W'(W_CTRL):  busRdData = {24'h0, ctrlByte};
      WA_W'(W_DATA):  busRdData = {24'h0, rdByte};
      WA_W'(W_MASK):  busRdData = maskReg;
      default:        busRdData = 32'h0;
    endcase
  end
endmodule

// File: rtl/btmbChecker.sv
module btmbChecker import btmbPkg::*; #(
  parameter int DEPTH = 64,
  parameter int WA_W  = 3,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [WA_W-1:0]  wordAddr,
  input logic [31:0]      wrData,
  input logic             rxReady,
  input logic [LEN_W-1:0] inLen,
  input logic [LEN_W-1:0] outLen,
  input logic             lenNext
);
  localparam logic [LEN_W-1:0] FULL = LEN_W'(DEPTH);
  logic ctrlWr, dataWr;
  assign ctrlWr = wrEn && (wordAddr == WA_W'(W_CTRL));
  assign dataWr = wrEn && (wordAddr == WA_W'(W_DATA));

  a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && wrData[C_CLR_WR]) |=> (outLen == '0));

  a_r4_length_next: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !wrData[C_CLR_WR] && wrData[C_CLR_RD]) |=> lenNext);

  a_r7_append_one: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && outLen != FULL) |=> (outLen == LEN_W'($past(outLen) + 1'b1)));

  a_r7_full_holds: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && outLen == FULL) |=> $stable(outLen));

  a_r10_no_take: assert property (@(posedge clk) disable iff (!rstN)
    (!rxReady && !ctrlWr) |=> $stable(inLen));

  a_r11_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (inLen <= FULL) && (outLen <= FULL));
endmodule

bind btMailbox btmbChecker #(.DEPTH(DEPTH), .WA_W(WA_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(busWrEn), .wordAddr(wordAddr),
  .wrData(busWrData), .rxReady(rxReady), .inLen(inLen), .outLen(outLen),
  .lenNext(lenNext)
);

// File: tb/btMailbox_test.sv
module btMailbox_test;
  localparam int DEPTH = 64;
  localparam logic [4:0] A_CFG = 5'h00, A_IEN = 5'h04, A_STS = 5'h08, A_SPARE = 5'h0C,
                         A_CTRL = 5'h10, A_DATA = 5'h14, A_MASK = 5'h18, A_NONE = 5'h1C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [4:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic irq, rxReady, txValid;
  logic rxValid = 1'b0;
  logic [7:0] rxByte = '0;
  logic [7:0] txByte;
  logic txReady = 1'b1;

  int checks = 0;
  int failures = 0;
  logic [7:0] txCap [0:79];
  int txCnt = 0;

  always #4 clk = ~clk;

  btMailbox #(.DEPTH(DEPTH), .ADDR_W(5)) uut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData), .irq(irq),
    .rxValid(rxValid), .rxByte(rxByte), .rxReady(rxReady),
    .txValid(txValid), .txByte(txByte), .txReady(txReady)
  );

  // Outbound stream capture: each cycle with valid and ready is one byte
  always @(negedge clk) begin
    if (rstN && txValid && txReady && txCnt < 80) begin
      txCap[txCnt] = txByte;
      txCnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic rxPush(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxByte = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 rxReady", {31'h0, rxReady}, 32'h1);
    chk("R1 txValid", {31'h0, txValid}, 32'h0);
    busRead(A_CFG, v);   chk("R1 cfg", v, 0);
    busRead(A_IEN, v);   chk("R1 ien", v, 0);
    busRead(A_STS, v);   chk("R1 sts", v, 0);
    busRead(A_CTRL, v);  chk("R1 ctrl", v, 0);
    busRead(A_MASK, v);  chk("R1 mask", v, 0);
    busRead(A_DATA, v);  chk("R1 length byte", v, 0);
  endtask

  task automatic t_plainRegs();
    logic [31:0] v;
    busWrite(A_CFG, 32'hDEADBEEF);   busRead(A_CFG, v);   chk("R2 cfg", v, 32'hDEADBEEF);
    busWrite(A_SPARE, 32'h12345678); busRead(A_SPARE, v); chk("R2 spare", v, 32'h12345678);
    busWrite(A_MASK, 32'hA5A5_00FF); busRead(A_MASK, v);  chk("R2 mask", v, 32'hA5A5_00FF);
    busRead(A_NONE, v); chk("R2 unmapped", v, 0);
  endtask

  task automatic t_inbound();
    logic [31:0] v;
    busWrite(A_IEN, 32'h1);
    rxPush(8'h11); rxPush(8'h22); rxPush(8'h33); rxPush(8'hA0);
    idle(3);
    chk("R9 irq raised", {31'h0, irq}, 32'h1);
    chk("R10 held off while waiting", {31'h0, rxReady}, 32'h0);
    busRead(A_CTRL, v); chk("R11 H2B set", v, 32'h04);
    busRead(A_STS, v);  chk("R9 status bit0", v, 32'h01);
    rxPush(8'h44);                       // offered while held off
    busWrite(A_CTRL, 32'h80);            // busy on, keeps receive state
    busWrite(A_CTRL, 32'h04);            // clear H2B
    busRead(A_CTRL, v); chk("R5 H2B cleared busy set", v, 32'h80);
    busWrite(A_CTRL, 32'h02);
    busRead(A_DATA, v); chk("R8 length first", v, 3);
    busRead(A_DATA, v); chk("R8 byte0", v, 32'h11);
    busRead(A_DATA, v); chk("R8 byte1", v, 32'h22);
    busRead(A_DATA, v); chk("R10 byte2 no extra byte", v, 32'h33);
    busRead(A_DATA, v); chk("R8 past end", v, 0);
    busWrite(A_CTRL, 32'h02);
    busRead(A_DATA, v); chk("R4 length again", v, 3);
    busWrite(A_STS, 32'h1);
    idle(1);
    chk("R9 irq cleared by w1c", {31'h0, irq}, 32'h0);
    busWrite(A_CTRL, 32'h80);            // busy off -> receive reset
    chk("R12 rxReady back", {31'h0, rxReady}, 32'h1);
    busWrite(A_CTRL, 32'h80);
    busWrite(A_CTRL, 32'h02);
    busRead(A_DATA, v); chk("R12 length cleared", v, 0);
    busWrite(A_CTRL, 32'h80);
  endtask

  task automatic t_frame();
    logic [31:0] v;
    busWrite(A_IEN, 32'h0);
    rxPush(8'h55); rxPush(8'hA1);                  // command frame discarded
    rxPush(8'hAA); rxPush(8'hB0); rxPush(8'h07);
    rxPush(8'hAA); rxPush(8'hBA); rxPush(8'hA0);
    idle(3);
    busRead(A_CTRL, v); chk("R11 escaped message end", v, 32'h04);
    busRead(A_STS, v);  chk("R9 no status when disabled", v, 0);
    chk("R10 ready when not waiting", {31'h0, rxReady}, 32'h1);
    busWrite(A_CTRL, 32'h80);
    busWrite(A_CTRL, 32'h02);
    busRead(A_DATA, v); chk("R11 length after discard", v, 3);
    busRead(A_DATA, v); chk("R11 escape A0", v, 32'hA0);
    busRead(A_DATA, v); chk("R11 plain 07", v, 32'h07);
    busRead(A_DATA, v); chk("R11 escape AA", v, 32'hAA);
    busWrite(A_CTRL, 32'h80);
    busWrite(A_CTRL, 32'h04);
    busRead(A_CTRL, v); chk("R5 flags clear", v, 0);
    rxPush(8'hA0);
    busRead(A_CTRL, v); chk("R11 empty end ignored", v, 0);
    rxPush(8'h01); rxPush(8'hAA); rxPush(8'hA0);
    busRead(A_CTRL, v); chk("R11 end during escape ignored", v, 0);
    busWrite(A_CTRL, 32'h40);                       // no command bit
    busRead(A_CTRL, v); chk("R5 unexpected write no flag", v, 0);
    busWrite(A_CTRL, 32'h80);
    busWrite(A_CTRL, 32'h02);
    busRead(A_DATA, v); chk("R12 reset by any write", v, 0);
    busWrite(A_CTRL, 32'h80);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    for (int i = 0; i < DEPTH + 2; i++) rxPush(8'(i + 1));
    rxPush(8'hA0);
    busRead(A_CTRL, v); chk("R11 overflow end ignored", v, 0);
    busWrite(A_CTRL, 32'h80);
    busWrite(A_CTRL, 32'h02);
    busRead(A_DATA, v); chk("R11 length capped", v, DEPTH);
    busWrite(A_CTRL, 32'h80);
  endtask

  task automatic t_outbound();
    logic [31:0] v;
    busWrite(A_IEN, 32'h40);
    busWrite(A_DATA, 32'hFFFFFF12);
    busWrite(A_DATA, 32'h00000034);
    busWrite(A_DATA, 32'hABCDEF56);
    txCnt = 0;
    busWrite(A_CTRL, 32'h08);
    busRead(A_CTRL, v); chk("R6 B2H and H_BUSY during send", v, 32'h48);
    idle(10);
    chk("R6 byte count", txCnt, 3);
    chk("R6 byte0", {24'h0, txCap[0]}, 32'h12);
    chk("R6 byte1", {24'h0, txCap[1]}, 32'h34);
    chk("R6 byte2", {24'h0, txCap[2]}, 32'h56);
    busRead(A_CTRL, v); chk("R6 bits cleared", v, 0);
    busRead(A_STS, v);  chk("R9 status bit6", v, 32'h40);
    chk("R9 irq from host busy", {31'h0, irq}, 32'h1);
    busWrite(A_STS, 32'h40);
    idle(1);
    chk("R9 irq drop", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    busWrite(A_IEN, 32'h0);
    txCnt = 0;
    busWrite(A_CTRL, 32'h09);                       // clear-write beats send
    idle(6);
    chk("R3 no send on 0x09", txCnt, 0);
    busRead(A_CTRL, v); chk("R3 no flag on 0x09", v, 0);
    busWrite(A_CTRL, 32'h08);
    idle(6);
    chk("R3 buffer emptied", txCnt, 0);
    busWrite(A_CTRL, 32'h84);                       // H2B clear beats busy toggle
    busRead(A_CTRL, v); chk("R3 busy not toggled", v, 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH + 2; i++) busWrite(A_DATA, 32'(i));
    txCnt = 0;
    busWrite(A_CTRL, 32'h08);
    idle(DEPTH + 10);
    chk("R7 capped at depth", txCnt, DEPTH);
    chk("R7 last kept byte", {24'h0, txCap[DEPTH-1]}, DEPTH - 1);
    busWrite(A_CTRL, 32'h01);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(5);
    rstN = 1'b1;
    idle(1);
    t_reset();
    t_plainRegs();
    t_inbound();
    t_frame();
    t_overflow();
    t_outbound();
    t_priority();
    t_full();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule